// File: doc/BRIEF.md
# Pad Mode Controller for an Infrared and General-Purpose Pin Group

This block turns a handful of register bits into per-pin pad controls for eight pins: an infrared transmit pin, an infrared receive pin and a six-bit general-purpose port. It gives each pin three registered pad controls: drive enable, drive value and weak-pullup enable.

Software programs the block through a simple write strobe with a two-bit address. It reads the registers back through a combinational read path. On the port pins and the transmit pin, one data bit has two meanings. When the pin is an output, the bit is the level driven. When the pin is an input, the bit selects weak pullup or three-state. When the infrared timer is enabled, it takes over the transmit pin.

There are two classes of reset. An ordinary reset clears every register. A power-fail reset clears every register except the port direction register, which keeps its value.

Top module: `padmode_ctrl`

## Requirements
- R1: During any reset, and on the first cycle after it, every pad output (`pad_oe`, `pad_out`, `pad_pu`) is 0. The infrared control register and the port data register clear on both reset classes.
- R2: The port direction register clears on an ordinary reset (`rst_pf`=0). It keeps its value when `rst_pf`=1 during reset.
- R3: A write is captured on the rising edge where `bus_wr`=1. Read-back shows the new value after that edge. The pads follow one edge later.
- R4: Pad index 0 is the transmit pin. With `irt_en`=0 and output-enable (control bit 1) at 1, the pin drives the level bit (control bit 0) and its pullup is off.
- R5: With `irt_en`=0 and control bit 1 at 0, the transmit pin does not drive. Control bit 0 at 1 gives weak pullup; at 0 it gives three-state.
- R6: With `irt_en`=1, transmit drive enable equals `irt_oe`. Transmit drive value equals `irt_oe & irt_lvl`. Transmit pullup is 0. Control bits 0 and 1 have no effect.
- R7: Pad index 1 is the receive pin. It never drives. Its pullup equals control bit 2.
- R8: Pad index 2+k is port bit k. With direction bit k at 1, it drives data bit k and its pullup is off.
- R9: With direction bit k at 0, port pin k does not drive. Data bit k at 1 gives weak pullup; at 0 it gives three-state.
- R10: Address 0 reads the control register in bits 2:0, with bits 7:3 at zero. Address 1 reads direction in bits 5:0, and address 2 reads data in bits 5:0; in both, bits 7:6 read zero. Address 3 reads zero.
- R11: No pin ever has drive enable and pullup enable set at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_pf | input | 1 | Marks the active reset as a power-fail reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read-back data for `bus_addr` |
| irt_en | input | 1 | Infrared timer enabled |
| irt_oe | input | 1 | Timer drive request for the transmit pin |
| irt_lvl | input | 1 | Timer output level |
| pad_oe | output | 8 | Per-pin drive enable (0 = transmit, 1 = receive, 2+k = port k) |
| pad_out | output | 8 | Per-pin drive value |
| pad_pu | output | 8 | Per-pin weak-pullup enable |

## Verification
A corrupted register bit appears on `bus_rdata` as soon as its address is selected. It appears on the matching pad output one clock later, as a pin that drives when it should float, or as a pull that switched the wrong way. A direction register lost across a power-fail reset shows up in read-back on the first cycle after reset, and on the pads one cycle after that. A broken timer hand-over shows on pad 0 one clock after `irt_en` changes.

// File: rtl/padmode_pkg.sv
package padmode_pkg;
  localparam logic [1:0] A_CTL = 2'd0;
  localparam logic [1:0] A_DIR = 2'd1;
  localparam logic [1:0] A_DAT = 2'd2;

  typedef struct packed {
    logic oe;
    logic val;
    logic pu;
  } pad_ctl_t;

  // shared bit: drive level when output, pull select when input
  function automatic pad_ctl_t dual_pad(input logic drive, input logic bitv);
    pad_ctl_t r;
    r.oe  = drive;
    r.val = drive & bitv;
    r.pu  = ~drive & bitv;
    return r;
  endfunction

  function automatic pad_ctl_t tx_pad(input logic tmr_en, input logic tmr_oe,
                                      input logic tmr_lvl, input logic reg_oe,
                                      input logic reg_lvl);
    pad_ctl_t r;
    if (tmr_en) begin
      r.oe  = tmr_oe;
      r.val = tmr_oe & tmr_lvl;
      r.pu  = 1'b0;
    end else begin
      r = dual_pad(reg_oe, reg_lvl);
    end
    return r;
  endfunction

  function automatic pad_ctl_t rx_pad(input logic pull);
    pad_ctl_t r;
    r.oe  = 1'b0;
    r.val = 1'b0;
    r.pu  = pull;
    return r;
  endfunction
endpackage

// File: rtl/padmode_regs.sv
module padmode_regs
  import padmode_pkg::*;
#(
  parameter int PORT_W = 6,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_pf,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              tx_lvl,
  output logic              tx_oe,
  output logic              rx_pull,
  output logic [PORT_W-1:0] port_dir,
  output logic [PORT_W-1:0] port_dat
);
  localparam int CTL_W = 3;

  logic wr_ctl, wr_dir, wr_dat;
  assign wr_ctl = bus_wr && (bus_addr == A_CTL);
  assign wr_dir = bus_wr && (bus_addr == A_DIR);
  assign wr_dat = bus_wr && (bus_addr == A_DAT);

  // cleared by every reset class
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_lvl   <= 1'b0;
      tx_oe    <= 1'b0;
      rx_pull  <= 1'b0;
      port_dat <= '0;
    end else begin
      if (wr_ctl) begin
        tx_lvl  <= bus_wdata[0];
        tx_oe   <= bus_wdata[1];
        rx_pull <= bus_wdata[2];
      end
      if (wr_dat) port_dat <= bus_wdata[PORT_W-1:0];
    end
  end

  // survives a power-fail reset
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if (!rst_pf) port_dir <= '0;
    end else if (wr_dir) begin
      port_dir <= bus_wdata[PORT_W-1:0];
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_CTL:   bus_rdata = DW'({rx_pull, tx_oe, tx_lvl});
      A_DIR:   bus_rdata = DW'(port_dir);
      A_DAT:   bus_rdata = DW'(port_dat);
      default: bus_rdata = '0;
    endcase
  end

  logic unused_w;
  assign unused_w = ^{CTL_W};
endmodule

// File: rtl/padmode_map.sv
module padmode_map
  import padmode_pkg::*;
#(
  parameter int PORT_W = 6,
  localparam int NPIN  = PORT_W + 2
) (
  input  logic              irt_en,
  input  logic              irt_oe,
  input  logic              irt_lvl,
  input  logic              tx_lvl,
  input  logic              tx_oe,
  input  logic              rx_pull,
  input  logic [PORT_W-1:0] port_dir,
  input  logic [PORT_W-1:0] port_dat,
  output logic [NPIN-1:0]   nx_oe,
  output logic [NPIN-1:0]   nx_out,
  output logic [NPIN-1:0]   nx_pu
);
  pad_ctl_t tx_c, rx_c;
  assign tx_c = tx_pad(irt_en, irt_oe, irt_lvl, tx_oe, tx_lvl);
  assign rx_c = rx_pad(rx_pull);

  assign nx_oe[0]  = tx_c.oe;
  assign nx_out[0] = tx_c.val;
  assign nx_pu[0]  = tx_c.pu;
  assign nx_oe[1]  = rx_c.oe;
  assign nx_out[1] = rx_c.val;
  assign nx_pu[1]  = rx_c.pu;

  for (genvar k = 0; k < PORT_W; k++) begin : g_port
    pad_ctl_t pc;
    assign pc          = dual_pad(port_dir[k], port_dat[k]);
    assign nx_oe[k+2]  = pc.oe;
    assign nx_out[k+2] = pc.val;
    assign nx_pu[k+2]  = pc.pu;
  end
endmodule

// File: rtl/padmode_padreg.sv
module padmode_padreg #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] nx_oe,
  input  logic [N-1:0] nx_out,
  input  logic [N-1:0] nx_pu,
  output logic [N-1:0] pad_oe,
  output logic [N-1:0] pad_out,
  output logic [N-1:0] pad_pu
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pad_oe  <= '0;
      pad_out <= '0;
      pad_pu  <= '0;
    end else begin
      pad_oe  <= nx_oe;
      pad_out <= nx_out;
      pad_pu  <= nx_pu;
    end
  end
endmodule

// File: rtl/padmode_ctrl.sv
module padmode_ctrl #(
  parameter int PORT_W = 6,
  parameter int DW     = 8,
  localparam int NPIN  = PORT_W + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rst_pf,
  input  logic            bus_wr,
  input  logic [1:0]      bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic            irt_en,
  input  logic            irt_oe,
  input  logic            irt_lvl,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_pu
);
  logic              tx_lvl, tx_oe, rx_pull;
  logic [PORT_W-1:0] port_dir, port_dat;
  logic [NPIN-1:0]   nx_oe, nx_out, nx_pu;

  padmode_regs #(.PORT_W(PORT_W), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .rst_pf(rst_pf),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .tx_lvl(tx_lvl), .tx_oe(tx_oe), .rx_pull(rx_pull),
    .port_dir(port_dir), .port_dat(port_dat)
  );

  padmode_map #(.PORT_W(PORT_W)) u_map (
    .irt_en(irt_en), .irt_oe(irt_oe), .irt_lvl(irt_lvl),
    .tx_lvl(tx_lvl), .tx_oe(tx_oe), .rx_pull(rx_pull),
    .port_dir(port_dir), .port_dat(port_dat),
    .nx_oe(nx_oe), .nx_out(nx_out), .nx_pu(nx_pu)
  );

  padmode_padreg #(.N(NPIN)) u_pads (
    .clk(clk), .rst_n(rst_n),
    .nx_oe(nx_oe), .nx_out(nx_out), .nx_pu(nx_pu),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );
endmodule

// File: rtl/padmode_chk.sv
module padmode_chk #(
  parameter int PORT_W = 6,
  parameter int DW     = 8,
  localparam int NPIN  = PORT_W + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        bus_addr,
  input logic [DW-1:0]     bus_rdata,
  input logic              irt_en,
  input logic              irt_oe,
  input logic              irt_lvl,
  input logic [PORT_W-1:0] port_dir,
  input logic [PORT_W-1:0] port_dat,
  input logic              rx_pull,
  input logic [NPIN-1:0]   pad_oe,
  input logic [NPIN-1:0]   pad_out,
  input logic [NPIN-1:0]   pad_pu
);
  a_r11_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_pu) == '0);

  a_r1_pads_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (pad_oe == '0 && pad_out == '0 && pad_pu == '0));

  // R8 and R9: port pads follow the registers one edge later
  a_r8_port_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (pad_oe[NPIN-1:2] == $past(port_dir)
                      && pad_pu[NPIN-1:2] == ($past(port_dat) & ~$past(port_dir))));

  a_r6_timer_owns_tx: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(irt_en)) |->
      (pad_oe[0] == $past(irt_oe) && pad_out[0] == $past(irt_oe & irt_lvl) && !pad_pu[0]));

  a_r7_rx_pull: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (!pad_oe[1] && pad_pu[1] == $past(rx_pull)));

  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd1 || bus_addr == 2'd2) |-> bus_rdata[DW-1:PORT_W] == '0);
endmodule

bind padmode_ctrl padmode_chk #(.PORT_W(PORT_W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .irt_en(irt_en), .irt_oe(irt_oe), .irt_lvl(irt_lvl),
  .port_dir(port_dir), .port_dat(port_dat), .rx_pull(rx_pull),
  .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
);

// File: tb/sim_padmode_ctrl.sv
module sim_padmode_ctrl;
  logic       clk = 1'b0;
  logic       rst_n, rst_pf, bus_wr, irt_en, irt_oe, irt_lvl;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata, pad_oe, pad_out, pad_pu;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  padmode_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .rst_pf(rst_pf), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irt_en(irt_en), .irt_oe(irt_oe), .irt_lvl(irt_lvl),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // register write; returns at the negedge after the capturing edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic do_reset(input logic pf);
    @(negedge clk);
    rst_n = 1'b0; rst_pf = pf;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1; rst_pf = 1'b0;
  endtask

  // check pads for given transmit / receive / port state (own model)
  task automatic chk_pads(input string req, input logic t_oe, input logic t_val,
                          input logic t_pu, input logic r_pu,
                          input logic [5:0] dir, input logic [5:0] dat);
    logic [7:0] e_oe, e_out, e_pu;
    e_oe  = {dir, 1'b0, t_oe};
    e_out = {dir & dat, 1'b0, t_val};
    e_pu  = {~dir & dat, r_pu, t_pu};
    chk({req, " oe"}, pad_oe, e_oe);
    chk({req, " out"}, pad_out, e_out);
    chk({req, " pu"}, pad_pu, e_pu);
  endtask

  task automatic t_reset_state;
    logic [7:0] d;
    wr(2'd0, 8'h07); wr(2'd1, 8'h3F); wr(2'd2, 8'h2A);
    do_reset(1'b0);
    chk("R1 oe after reset", pad_oe, 8'h00);
    chk("R1 pu after reset", pad_pu, 8'h00);
    rd(2'd0, d); chk("R1 ctl cleared", d, 8'h00);
    rd(2'd2, d); chk("R1 dat cleared", d, 8'h00);
    rd(2'd1, d); chk("R2 dir cleared by ordinary reset", d, 8'h00);
  endtask

  task automatic t_pf_reset;
    logic [7:0] d;
    wr(2'd1, 8'h15); wr(2'd2, 8'h3F); wr(2'd0, 8'h04);
    do_reset(1'b1);
    chk("R1 out after pf reset", pad_out, 8'h00);
    rd(2'd1, d); chk("R2 dir kept by pf reset", d, 8'h15);
    rd(2'd2, d); chk("R1 dat cleared by pf reset", d, 8'h00);
    rd(2'd0, d); chk("R1 ctl cleared by pf reset", d, 8'h00);
    @(negedge clk);
    chk_pads("R2 pads after pf reset", 0, 0, 0, 0, 6'h15, 6'h00);
  endtask

  task automatic t_write_timing;
    logic [7:0] d;
    wr(2'd2, 8'h00); wr(2'd1, 8'h00);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h3F;
    #1; chk("R3 no change before edge", bus_rdata, 8'h00);
    @(negedge clk); bus_wr = 1'b0;
    rd(2'd1, d); chk("R3 readback after edge", d, 8'h3F);
    chk("R3 pad lags one edge", pad_oe, 8'h00);
    @(negedge clk);
    chk("R3 pad after second edge", pad_oe, 8'hFC);
  endtask

  task automatic t_tx_output;
    wr(2'd0, 8'h03); @(negedge clk);
    chk_pads("R4 tx drive high", 1, 1, 0, 0, 6'h3F, 6'h00);
    wr(2'd0, 8'h02); @(negedge clk);
    chk_pads("R4 tx drive low", 1, 0, 0, 0, 6'h3F, 6'h00);
  endtask

  task automatic t_tx_input;
    wr(2'd0, 8'h01); @(negedge clk);
    chk_pads("R5 tx weak pullup", 0, 0, 1, 0, 6'h3F, 6'h00);
    wr(2'd0, 8'h00); @(negedge clk);
    chk_pads("R5 tx three-state", 0, 0, 0, 0, 6'h3F, 6'h00);
  endtask

  task automatic t_timer;
    wr(2'd0, 8'h01);
    irt_en = 1'b1; irt_oe = 1'b1; irt_lvl = 1'b1;
    @(negedge clk);
    chk_pads("R6 timer drives high", 1, 1, 0, 0, 6'h3F, 6'h00);
    irt_lvl = 1'b0; @(negedge clk);
    chk_pads("R6 timer drives low", 1, 0, 0, 0, 6'h3F, 6'h00);
    wr(2'd0, 8'h03); @(negedge clk);
    chk_pads("R6 reg bits ignored", 1, 0, 0, 0, 6'h3F, 6'h00);
    irt_oe = 1'b0; irt_lvl = 1'b1; @(negedge clk);
    chk_pads("R6 timer releases", 0, 0, 0, 0, 6'h3F, 6'h00);
    irt_en = 1'b0; irt_oe = 1'b0; irt_lvl = 1'b0; @(negedge clk);
    chk_pads("R6 back to register", 1, 1, 0, 0, 6'h3F, 6'h00);
  endtask

  task automatic t_rx;
    wr(2'd0, 8'h04); @(negedge clk);
    chk_pads("R7 rx pullup on", 0, 0, 0, 1, 6'h3F, 6'h00);
    wr(2'd0, 8'h00); @(negedge clk);
    chk_pads("R7 rx three-state", 0, 0, 0, 0, 6'h3F, 6'h00);
  endtask

  task automatic t_port;
    wr(2'd1, 8'h3F); wr(2'd2, 8'h25); @(negedge clk);
    chk_pads("R8 all outputs", 0, 0, 0, 0, 6'h3F, 6'h25);
    wr(2'd1, 8'h00); @(negedge clk);
    chk_pads("R9 all inputs", 0, 0, 0, 0, 6'h00, 6'h25);
    wr(2'd1, 8'h0F); wr(2'd2, 8'h3A); @(negedge clk);
    chk_pads("R8 R9 mixed", 0, 0, 0, 0, 6'h0F, 6'h3A);
    chk("R11 no pin drives and pulls", pad_oe & pad_pu, 8'h00);
  endtask

  task automatic t_readback;
    logic [7:0] d;
    wr(2'd0, 8'hFF); wr(2'd1, 8'hFF); wr(2'd2, 8'hC0);
    rd(2'd0, d); chk("R10 ctl reserved zero", d, 8'h07);
    rd(2'd1, d); chk("R10 dir reserved zero", d, 8'h3F);
    rd(2'd2, d); chk("R10 dat reserved zero", d, 8'h00);
    rd(2'd3, d); chk("R10 unused address", d, 8'h00);
    @(negedge clk);
    chk("R11 tx drives without pull", pad_oe & pad_pu, 8'h00);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0; rst_pf = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00;
    irt_en = 1'b0; irt_oe = 1'b0; irt_lvl = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_pf_reset();
    t_write_timing();
    t_tx_output();
    t_tx_input();
    t_timer();
    t_rx();
    t_port();
    t_readback();
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end
endmodule